// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the interrupt and status registers of a CMOS-style real-time clock. It takes two event sources. A once-per-second update strobe comes in from the calendar logic. A programmable periodic tick is generated internally from a prescaled clock enable. Each source sets its own status flag. The enabled sources also set a master interrupt-request flag, and that flag drives an active-high interrupt line.

Software reaches the block through a small synchronous register bus of four byte-wide registers. The first is a rate register, which also carries a read-only busy bit. The second is a control register holding the SET bit and the enable bits. The third is a read-to-clear flag register. The fourth is a read-only status register. A read returns its data one clock after the strobe. Reading the flag register is how the interrupt is acknowledged.

Top module: `rtc_irq_flags`

## Requirements
- R1: After synchronous reset, rd_data is 0x00, irq is low, all flag bits read 0, and the rate and control registers are 0x00.
- R2: Address 0 is the rate register. Bit 7 is a read-only busy bit that resets to 0. A write updates bits 6:0 and keeps bit 7. A read returns the stored value one cycle after the read strobe.
- R3: Address 1 is the control register: bit 7 SET, bit 6 periodic enable, bit 4 update enable. Address 2 is the flag register: bit 7 master request, bit 6 periodic flag, bit 4 update flag. A sec_tick while SET is 0 sets the update flag on the next edge, even when the update enable is 0.
- R4: A sec_tick while SET is 0 and the update enable is 1 also sets the master request flag. irq is high from the following cycle.
- R5: While SET is 1, sec_tick has no effect on any flag or on irq.
- R6: A rate select of N = 1..15 in rate bits 3:0 sets the periodic flag once every 2^(N-1) pre_tick pulses. With the periodic enable at 0, the master flag and irq are left untouched.
- R7: A periodic event while the periodic enable is 1 sets the master request flag and raises irq from the following cycle.
- R8: A read of address 2 returns the flag value held before the read. All flags and irq clear on the edge that captures the read.
- R9: An event in the same cycle as a flag register read still sets its flags after the clear.
- R10: A rate select of 0 stops the periodic tick entirely.
- R11: Writes to address 2 and address 3 are ignored. Address 3 always reads 0x80.
- R12: Any write to address 0 or address 1 restarts the periodic count from zero. A tick that falls in the write cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle update-ended strobe, once per second |
| pre_tick | input | 1 | Prescaled clock enable for the periodic divider |
| irq | output | 1 | Active-high interrupt request |

## Verification
The directed part drives update strobes under the three control settings: enable off, enable on, and SET on. These tell flag-only latching apart from a real interrupt and from full suppression. Periodic ticks are counted one pulse short of the period and then at the period, for several rate codes including 0. A restart is forced partway through a count, which separates a divider that restarts on a write from one that runs freely. Events are placed in the same cycle as a flag read to expose clear-over-set priority errors. A long random run of mixed reads, writes and events is then compared cycle by cycle against a behavioural model.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] ADR_RATE = 2'd0;
  localparam logic [1:0] ADR_CTRL = 2'd1;
  localparam logic [1:0] ADR_FLAG = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;
  localparam int BIT_BUSY = 7;
  localparam int BIT_SET  = 7;
  localparam int BIT_PEN  = 6;
  localparam int BIT_UEN  = 4;
  localparam int BIT_MST  = 7;
  localparam int BIT_PFL  = 6;
  localparam int BIT_UFL  = 4;
  localparam logic [DATA_W-1:0] STAT_VALUE = 8'h80;
endpackage

// File: rtl/rtcif_rate_gen.sv
module rtcif_rate_gen #(
  parameter int RATE_W = 4,
  parameter int CNT_W  = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              pre_tick,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;
  logic             active;

  always_comb begin
    active = (rate_sel != '0);
    target = (ONE << (rate_sel - 1'b1)) - ONE;
    tick   = active && !restart && pre_tick && (cnt_q == target);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt_q <= '0;
    end else if (pre_tick) begin
      if (cnt_q == target) cnt_q <= '0;
      else                 cnt_q <= cnt_q + ONE;
    end
  end

  // R6: the divider count stays inside the selected period
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q <= target));

  // R10: a zero rate keeps the divider parked at zero
  a_r10_idle_parked: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt_q == '0));
endmodule

// File: rtl/rtcif_upd_gate.sv
module rtcif_upd_gate (
  input  logic sec_tick,
  input  logic set_bit,
  input  logic uen_bit,
  output logic upd_evt,
  output logic upd_req
);
  always_comb begin
    upd_evt = sec_tick && !set_bit;
    upd_req = upd_evt && uen_bit;
  end
endmodule

// File: rtl/rtcif_flags.sv
module rtcif_flags
  import rtcif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              per_evt,
  input  logic              per_req,
  input  logic              upd_evt,
  input  logic              upd_req,
  output logic [DATA_W-1:0] flags,
  output logic              irq
);
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] nxt;
  logic              irq_q;

  always_comb begin
    base = clr ? '0 : flags_q;
    nxt  = base;
    if (per_evt) nxt[BIT_PFL] = 1'b1;
    if (upd_evt) nxt[BIT_UFL] = 1'b1;
    if (per_req || upd_req) nxt[BIT_MST] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= nxt;
      irq_q   <= nxt[BIT_MST];
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  // R8: a read with no fresh event leaves everything clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr && !per_evt && !upd_evt) |=> (flags_q == '0 && !irq_q));

  // R9: an event coinciding with a read survives the clear
  a_r9_event_survives: assert property (@(posedge clk) disable iff (rst)
    (clr && upd_evt) |=> flags_q[BIT_UFL]);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtcif_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sec_tick,
  input  logic              pre_tick,
  output logic              irq
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [DATA_W-1:0] reg_rate_q;
  logic [DATA_W-1:0] reg_ctrl_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] flags;
  logic              wr_rate, wr_ctrl, rd_flag;
  logic              per_evt, per_req, upd_evt, upd_req;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    wr_rate = wr_en && (addr == ADR_RATE);
    wr_ctrl = wr_en && (addr == ADR_CTRL);
    rd_flag = rd_en && (addr == ADR_FLAG);
    per_req = per_evt && reg_ctrl_q[BIT_PEN];
    unique case (addr)
      ADR_RATE: rd_mux = reg_rate_q;
      ADR_CTRL: rd_mux = reg_ctrl_q;
      ADR_FLAG: rd_mux = flags;
      default:  rd_mux = STAT_VALUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rate_q <= '0;
      reg_ctrl_q <= '0;
      rd_q       <= '0;
    end else begin
      if (wr_rate) reg_rate_q <= {reg_rate_q[BIT_BUSY], wr_data[BIT_BUSY-1:0]};
      if (wr_ctrl) reg_ctrl_q <= wr_data;
      if (rd_en)   rd_q <= rd_mux;
    end
  end

  rtcif_rate_gen #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_rate || wr_ctrl),
    .pre_tick (pre_tick),
    .rate_sel (reg_rate_q[RATE_W-1:0]),
    .tick     (per_evt)
  );

  rtcif_upd_gate u_upd (
    .sec_tick (sec_tick),
    .set_bit  (reg_ctrl_q[BIT_SET]),
    .uen_bit  (reg_ctrl_q[BIT_UEN]),
    .upd_evt  (upd_evt),
    .upd_req  (upd_req)
  );

  rtcif_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .clr     (rd_flag),
    .per_evt (per_evt),
    .per_req (per_req),
    .upd_evt (upd_evt),
    .upd_req (upd_req),
    .flags   (flags),
    .irq     (irq)
  );

  assign rd_data = rd_q;

  // R2: the busy bit is not changed by a write
  a_r2_busy_kept: assert property (@(posedge clk) disable iff (rst)
    wr_rate |=> $stable(reg_rate_q[BIT_BUSY]));

  // R4: an enabled update event raises the interrupt line
  a_r4_upd_irq: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !reg_ctrl_q[BIT_SET] && reg_ctrl_q[BIT_UEN]) |=> irq);

  // R5: with SET high a second strobe cannot create the update flag
  a_r5_set_masks: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && reg_ctrl_q[BIT_SET] && !flags[BIT_UFL]) |=> !flags[BIT_UFL]);

  // R7: an enabled periodic event raises the interrupt line
  a_r7_per_irq: assert property (@(posedge clk) disable iff (rst)
    (per_evt && reg_ctrl_q[BIT_PEN]) |=> irq);

  // R11: bus writes to the flag register change nothing
  a_r11_flag_wr_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_FLAG && !rd_en && !per_evt && !upd_evt) |=> $stable(flags));
endmodule

// File: tb/rtc_irq_flags_tb.sv
module rtc_irq_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       sec_tick = 1'b0;
  logic       pre_tick = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_irq_flags dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sec_tick(sec_tick), .pre_tick(pre_tick),
    .irq(irq)
  );

  // behavioural reference
  int m_a, m_b, m_c, m_rd, m_irq, m_cnt;

  always @(posedge clk) begin
    int rs, per, upd, c, d;
    cycles++;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_rd = 0; m_irq = 0; m_cnt = 0;
    end else begin
      rs  = m_a % 16;
      per = 0;
      if ((wr_en && addr <= 1) || rs == 0) m_cnt = 0;
      else if (pre_tick) begin
        if (m_cnt == (1 << (rs - 1)) - 1) begin per = 1; m_cnt = 0; end
        else m_cnt++;
      end
      upd = (sec_tick && (m_b / 128) % 2 == 0) ? 1 : 0;
      if (rd_en) begin
        case (addr)
          2'd0: m_rd = m_a;
          2'd1: m_rd = m_b;
          2'd2: m_rd = m_c;
          default: m_rd = 128;
        endcase
      end
      c = (rd_en && addr == 2) ? 0 : m_c;
      if (per) begin
        c = c | 64;
        if ((m_b / 64) % 2 == 1) c = c | 128;
      end
      if (upd) begin
        c = c | 16;
        if ((m_b / 16) % 2 == 1) c = c | 128;
      end
      m_c = c;
      m_irq = c / 128;
      d = int'(wr_data);
      if (wr_en && addr == 0) m_a = (m_a / 128) * 128 + d % 128;
      if (wr_en && addr == 1) m_b = d;
    end
  end

  // per-cycle comparison against the model (R2/R3/R4/R6/R7/R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(rd_data) != m_rd) begin
        errors++;
        $display("FAIL R2/R8 model rd_data actual=%0h expected=%0h t=%0t", rd_data, m_rd, $time);
      end
      checks++;
      if (int'(irq) != m_irq) begin
        errors++;
        $display("FAIL R4/R7 model irq actual=%0d expected=%0d t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic sec();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic pre(input int n);
    for (int i = 0; i < n; i++) begin
      pre_tick = 1'b1;
      @(negedge clk);
    end
    pre_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 irq", int'(irq), 0);
    rd(2'd2, v); chk("R1 flags", v, 0);
    rd(2'd1, v); chk("R1 ctrl", v, 0);

    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 busy kept", v, 8'h7F);
    wr(2'd0, 8'h00);

    wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
    rd(2'd2, v); chk("R11 flag write", v, 0);
    rd(2'd3, v); chk("R11 status", v, 8'h80);

    wr(2'd1, 8'h00); sec();
    chk("R3 irq stays low", int'(irq), 0);
    rd(2'd2, v); chk("R3 update flag only", v, 8'h10);

    wr(2'd1, 8'h90); sec();
    rd(2'd2, v); chk("R5 set masks", v, 0);
    chk("R5 irq", int'(irq), 0);

    wr(2'd1, 8'h10); sec();
    chk("R4 irq high", int'(irq), 1);
    rd(2'd2, v); chk("R4 flags", v, 8'h90);
    chk("R8 irq cleared", int'(irq), 0);
    rd(2'd2, v); chk("R8 flags cleared", v, 0);

    addr = 2'd2; rd_en = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; sec_tick = 1'b0;
    chk("R9 read value", int'(rd_data), 0);
    chk("R9 irq", int'(irq), 1);
    rd(2'd2, v); chk("R9 flags", v, 8'h90);

    wr(2'd1, 8'h00); wr(2'd0, 8'h03); rd(2'd2, v);
    pre(3); rd(2'd2, v); chk("R6 short of period", v, 0);
    pre(1); chk("R6 irq untouched", int'(irq), 0);
    rd(2'd2, v); chk("R6 periodic flag", v, 8'h40);

    wr(2'd1, 8'h40); pre(4);
    chk("R7 irq", int'(irq), 1);
    rd(2'd2, v); chk("R7 flags", v, 8'hC0);

    wr(2'd0, 8'h03); pre(2); wr(2'd0, 8'h03); pre(3);
    rd(2'd2, v); chk("R12 restart", v, 0);
    pre(1); rd(2'd2, v); chk("R12 after restart", v, 8'hC0);

    wr(2'd0, 8'h01); pre(1); rd(2'd2, v); chk("R6 rate one", v, 8'hC0);

    wr(2'd0, 8'h00); pre(40);
    rd(2'd2, v); chk("R10 no tick", v, 0);

    for (int i = 0; i < 4000; i++) begin
      wr_en    = ($urandom_range(0, 7) == 0);
      rd_en    = ($urandom_range(0, 3) == 0);
      addr     = 2'($urandom_range(0, 3));
      wr_data  = 8'($urandom);
      if (addr == 2'd0) wr_data[3:0] = 4'($urandom_range(0, 4));
      pre_tick = ($urandom_range(0, 1) == 0);
      sec_tick = ($urandom_range(0, 39) == 0);
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0; pre_tick = 1'b0; sec_tick = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule